// File: doc/BRIEF.md
# Pin Bank with Level and Edge Detection

This block is one bank of general-purpose pins behind a 32-bit register bus. Each pin can drive a value or be read back, and each pin can raise an event status under any mix of four independently enabled conditions: input low, input high, a rising transition and a falling transition. The bank merges the enabled status bits into one interrupt line and, through a second enable set, into one wake-up request.

Pin inputs pass through a two-flop synchronizer before they are read or examined for events. Level-type status cannot be cleared while its level persists, because detection re-sets the bit on every clock. Edge-type status is a one-shot that stays set until software clears it. Output data, interrupt enable and wake-up enable can be changed through set-only and clear-only alias addresses, so software can change single bits without a read-modify-write.

The bus is a single-cycle write port with a combinational read port. Reads return the register at `bus_addr` in the same cycle. Writes take effect at the clock edge where `bus_we` is high.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the status, interrupt enable, wake-up enable, output data and all four detect-enable registers read 0. The direction register at 0x34 reads all ones. `irq`, `wake` and `pin_drive` are 0.
- R2: Address 0x00 returns the major version in bits [7:4] and the minor version in bits [3:0]. Address 0x14 returns 1 in bit 0, which reports that reset is complete.
- R3: Address 0x38 returns the pin inputs after two synchronizing flops, so a pin change first appears after the second rising clock edge. It follows the pins whatever the direction setting is.
- R4: A direction bit of 1 at 0x34 makes its pin an input, and `pin_drive` is its inverse. `pin_out` always carries the output-data register.
- R5: A write to 0x3C replaces every output-data bit. A write to 0x94 sets only the bits written as 1, and a write to 0x90 clears only the bits written as 1. Alias writes in back-to-back cycles are applied in order.
- R6: The interrupt enable is written directly at 0x1C, set bit-wise at 0x64 and cleared bit-wise at 0x60. Its value reads back at 0x1C and at 0x64.
- R7: The wake-up enable is set bit-wise at 0x84 and cleared bit-wise at 0x80. Its value reads back at 0x84.
- R8: With a low-detect bit (0x40) or a high-detect bit (0x44) set, the pin's status bit (0x18) sets on the third rising edge after the pin reaches that level. It keeps setting every cycle while the level holds.
- R9: With a rising-detect bit (0x48) or a falling-detect bit (0x4C) set, a matching transition sets the status bit once, on the third rising edge after the pin change. The bit stays set until it is cleared.
- R10: Writing 1 to a status bit at 0x18 clears that bit, and bits written as 0 are kept. A bit whose level condition still holds reads as set again in the very next cycle.
- R11: The four detect enables of a pin combine as an OR. A pin with all four enables at 0 never sets its status.
- R12: `irq` is high exactly when some status bit has its interrupt-enable bit set. `wake` is high exactly when some status bit has its wake-up-enable bit set.
- R13: Addresses 0x10 and 0x30 are plain 32-bit read/write storage. Any unmapped address reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Output-data register value |
| pin_drive | output | NPINS | 1 where the pin is driven as an output |
| irq | output | 1 | Bank interrupt |
| wake | output | 1 | Wake-up request |

## Verification
The bench builds the bank with NPINS = 8 and version 3.1. This makes an eight-bit pin vector small enough that every pattern pair can be worked out bit by bit in the bench. Each pin gets a different one of the sixteen combinations of detect enables, and the assignment rotates on every pass. Over sixteen passes, every combination meets every pin under several start/end pattern pairs, including all-low to all-high and mixed patterns. In each pass the bench predicts the status from the level and edge rules, and it checks the status before and after a clear and the two combined outputs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int DW = 32;
    localparam int AW = 8;

    typedef logic [AW-1:0] addr_t;

    // Register offsets (software-visible; kept fixed)
    localparam addr_t OFS_REV    = 8'h00;
    localparam addr_t OFS_CFG    = 8'h10;
    localparam addr_t OFS_SYSST  = 8'h14;
    localparam addr_t OFS_STAT   = 8'h18;
    localparam addr_t OFS_IE     = 8'h1C;
    localparam addr_t OFS_CTRL   = 8'h30;
    localparam addr_t OFS_DIR    = 8'h34;
    localparam addr_t OFS_DIN    = 8'h38;
    localparam addr_t OFS_DOUT   = 8'h3C;
    localparam addr_t OFS_LOW    = 8'h40;
    localparam addr_t OFS_HIGH   = 8'h44;
    localparam addr_t OFS_RISE   = 8'h48;
    localparam addr_t OFS_FALL   = 8'h4C;
    localparam addr_t OFS_IE_CLR = 8'h60;
    localparam addr_t OFS_IE_SET = 8'h64;
    localparam addr_t OFS_WK_CLR = 8'h80;
    localparam addr_t OFS_WK_SET = 8'h84;
    localparam addr_t OFS_DO_CLR = 8'h90;
    localparam addr_t OFS_DO_SET = 8'h94;

    // Kind of update a bus write applies to an aliased register
    typedef enum logic [1:0] {
        WOP_NONE = 2'd0,
        WOP_LOAD = 2'd1,
        WOP_SET  = 2'd2,
        WOP_CLR  = 2'd3
    } wop_e;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] low_en,
    input  logic [NPINS-1:0] high_en,
    input  logic [NPINS-1:0] rise_en,
    input  logic [NPINS-1:0] fall_en,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] hit,
    output logic [NPINS-1:0] stat
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic prev_q;
        logic stat_q;
        logic cond;

        always_comb begin
            cond = (low_en[i]  & ~lvl[i])
                 | (high_en[i] &  lvl[i])
                 | (rise_en[i] &  lvl[i] & ~prev_q)
                 | (fall_en[i] & ~lvl[i] &  prev_q);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                stat_q <= 1'b0;
            end else begin
                prev_q <= lvl[i];
                // a new detection outranks the clear in the same cycle
                stat_q <= (stat_q & ~clr[i]) | cond;
            end
        end

        assign hit[i]  = cond;
        assign stat[i] = stat_q;
    end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  addr_t            addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    cfg_q,
    output logic [DW-1:0]    ctrl_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] ie_q,
    output logic [NPINS-1:0] wk_q,
    output logic [NPINS-1:0] low_q,
    output logic [NPINS-1:0] high_q,
    output logic [NPINS-1:0] rise_q,
    output logic [NPINS-1:0] fall_q,
    output logic [NPINS-1:0] stat_clr
);
    logic [NPINS-1:0] wd;
    wop_e op_ie, op_wk, op_do;

    assign wd = wdata[NPINS-1:0];

    function automatic logic [NPINS-1:0] apply(input logic [NPINS-1:0] cur,
                                               input wop_e op,
                                               input logic [NPINS-1:0] d);
        logic [NPINS-1:0] r;
        unique case (op)
            WOP_LOAD: r = d;
            WOP_SET:  r = cur | d;
            WOP_CLR:  r = cur & ~d;
            default:  r = cur;
        endcase
        return r;
    endfunction

    always_comb begin
        op_ie = WOP_NONE;
        op_wk = WOP_NONE;
        op_do = WOP_NONE;
        if (we) begin
            if (addr == OFS_IE)          op_ie = WOP_LOAD;
            else if (addr == OFS_IE_SET) op_ie = WOP_SET;
            else if (addr == OFS_IE_CLR) op_ie = WOP_CLR;
            if (addr == OFS_WK_SET)      op_wk = WOP_SET;
            else if (addr == OFS_WK_CLR) op_wk = WOP_CLR;
            if (addr == OFS_DOUT)        op_do = WOP_LOAD;
            else if (addr == OFS_DO_SET) op_do = WOP_SET;
            else if (addr == OFS_DO_CLR) op_do = WOP_CLR;
        end
    end

    assign stat_clr = (we && addr == OFS_STAT) ? wd : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            ctrl_q <= '0;
            dir_q  <= '1;
            dout_q <= '0;
            ie_q   <= '0;
            wk_q   <= '0;
            low_q  <= '0;
            high_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            dout_q <= apply(dout_q, op_do, wd);
            ie_q   <= apply(ie_q, op_ie, wd);
            wk_q   <= apply(wk_q, op_wk, wd);
            if (we) begin
                case (addr)
                    OFS_CFG:  cfg_q  <= wdata;
                    OFS_CTRL: ctrl_q <= wdata;
                    OFS_DIR:  dir_q  <= wd;
                    OFS_LOW:  low_q  <= wd;
                    OFS_HIGH: high_q <= wd;
                    OFS_RISE: rise_q <= wd;
                    OFS_FALL: fall_q <= wd;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int          NPINS     = 32,
    parameter logic [3:0]  REV_MAJOR = 4'd2,
    parameter logic [3:0]  REV_MINOR = 4'd0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_drive,
    output logic             irq,
    output logic             wake
);
    localparam int SYNC_STAGES = 2;

    logic [DW-1:0]    cfg_q, ctrl_q;
    logic [NPINS-1:0] dir_q, dout_q, ie_q, wk_q;
    logic [NPINS-1:0] low_q, high_q, rise_q, fall_q;
    logic [NPINS-1:0] stat_clr, din_w, hit_w, stat_w;

    gpio_bank_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .cfg_q(cfg_q), .ctrl_q(ctrl_q), .dir_q(dir_q), .dout_q(dout_q),
        .ie_q(ie_q), .wk_q(wk_q), .low_q(low_q), .high_q(high_q),
        .rise_q(rise_q), .fall_q(fall_q), .stat_clr(stat_clr)
    );

    gpio_bank_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_w)
    );

    gpio_bank_detect #(.NPINS(NPINS)) u_det (
        .clk(clk), .rst_n(rst_n), .lvl(din_w),
        .low_en(low_q), .high_en(high_q), .rise_en(rise_q), .fall_en(fall_q),
        .clr(stat_clr), .hit(hit_w), .stat(stat_w)
    );

    assign pin_out   = dout_q;
    assign pin_drive = ~dir_q;
    assign irq       = |(stat_w & ie_q);
    assign wake      = |(stat_w & wk_q);

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:    bus_rdata[7:0] = {REV_MAJOR, REV_MINOR};
            OFS_SYSST:  bus_rdata[0] = 1'b1;
            OFS_CFG:    bus_rdata = cfg_q;
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_STAT:   bus_rdata[NPINS-1:0] = stat_w;
            OFS_IE,
            OFS_IE_SET: bus_rdata[NPINS-1:0] = ie_q;
            OFS_WK_SET: bus_rdata[NPINS-1:0] = wk_q;
            OFS_DIR:    bus_rdata[NPINS-1:0] = dir_q;
            OFS_DIN:    bus_rdata[NPINS-1:0] = din_w;
            OFS_DOUT:   bus_rdata[NPINS-1:0] = dout_q;
            OFS_LOW:    bus_rdata[NPINS-1:0] = low_q;
            OFS_HIGH:   bus_rdata[NPINS-1:0] = high_q;
            OFS_RISE:   bus_rdata[NPINS-1:0] = rise_q;
            OFS_FALL:   bus_rdata[NPINS-1:0] = fall_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [7:0]       bus_addr,
    input logic [NPINS-1:0] wd,
    input logic [NPINS-1:0] stat,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] ie,
    input logic [NPINS-1:0] wk,
    input logic [NPINS-1:0] dout,
    input logic             irq,
    input logic             wake
);
    logic [NPINS-1:0] clr_now;
    assign clr_now = (bus_we && bus_addr == OFS_STAT) ? wd : '0;

    // R12: interrupt needs a pending status and an enable
    a_r12_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat != '0 && ie != '0));
    a_r12_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (stat != '0 && wk != '0));
    // R10: written-1 bits are gone unless a condition re-detected them
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_STAT) |=> ((stat & $past(wd) & ~$past(hit)) == '0));
    // R9: status never drops without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~stat) & ~$past(clr_now)) == '0));
    // R8: a detection always lands in status
    a_r8_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((stat & $past(hit)) == $past(hit)));
    // R5: set and clear aliases
    a_r5_dout_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DO_SET) |=> ((dout & $past(wd)) == $past(wd)));
    a_r5_dout_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DO_CLR) |=> ((dout & $past(wd)) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .wd(bus_wdata[NPINS-1:0]), .stat(stat_w), .hit(hit_w), .ie(ie_q),
    .wk(wk_q), .dout(dout_q), .irq(irq), .wake(wake)
);

// File: tb/sim_gpio_bank.sv
`timescale 1ns/1ps
module sim_gpio_bank;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_out, pin_drive;
    logic         irq, wake;

    int n_chk = 0;
    int n_bad = 0;

    gpio_bank #(.NPINS(N), .REV_MAJOR(4'd3), .REV_MINOR(4'd1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_drive(pin_drive), .irq(irq), .wake(wake)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [N-1:0] lvl_hit(input logic [N-1:0] v, lo, hi);
        return (lo & ~v) | (hi & v);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);

        // R1 reset state
        rd(8'h18, r); chk("R1 status", r, 0);
        rd(8'h34, r); chk("R1 direction", r, 32'hFF);
        rd(8'h3C, r); chk("R1 dout", r, 0);
        rd(8'h1C, r); chk("R1 ie", r, 0);
        rd(8'h84, r); chk("R1 wk", r, 0);
        rd(8'h40, r); chk("R1 low detect", r, 0);
        chk("R1 irq/wake/drive", {irq, wake, pin_drive}, 0);

        // R2 identification
        rd(8'h00, r); chk("R2 revision", r, 32'h31);
        rd(8'h14, r); chk("R2 reset done", r, 1);

        // R13 storage and unmapped
        wr(8'h10, 32'hDEADBEEF); rd(8'h10, r); chk("R13 cfg", r, 32'hDEADBEEF);
        wr(8'h30, 32'h12345678); rd(8'h30, r); chk("R13 ctrl", r, 32'h12345678);
        rd(8'h20, r); chk("R13 unmapped", r, 0);

        // R4 direction
        wr(8'h34, 32'hF0);
        chk("R4 pin_drive", pin_drive, 8'h0F);

        // R3 synchronized input, pins on outputs too
        wr(8'h34, 32'h00);
        pin_in = 8'h5A;
        cycles(1); rd(8'h38, r); chk("R3 din after one edge", r, 0);
        cycles(1); rd(8'h38, r); chk("R3 din after two edges", r, 32'h5A);
        wr(8'h34, 32'hFF);

        // R5 output data
        wr(8'h3C, 32'hFFFFFFFF); rd(8'h3C, r); chk("R5 full write", r, 32'hFF);
        wr(8'h3C, 32'hA5);
        wr(8'h94, 32'h0F);
        wr(8'h90, 32'h03);
        rd(8'h3C, r); chk("R5 back-to-back set then clear", r, 32'hAC);
        chk("R4 pin_out", pin_out, 8'hAC);

        // R6 interrupt enable
        wr(8'h1C, 32'h3C);
        wr(8'h64, 32'h01); rd(8'h1C, r); chk("R6 set alias", r, 32'h3D);
        wr(8'h60, 32'h0C); rd(8'h64, r); chk("R6 clear alias", r, 32'h31);

        // R7 wake-up enable
        wr(8'h84, 32'h81);
        wr(8'h80, 32'h01); rd(8'h84, r); chk("R7 wake enable", r, 32'h80);

        // R12 / R10 with a persistent high level on pin 2
        wr(8'h1C, 32'h00); wr(8'h80, 32'hFF);
        pin_in = 8'h04; cycles(4);
        wr(8'h18, 32'hFF);
        wr(8'h44, 32'h04); cycles(1);
        rd(8'h18, r); chk("R8 high level", r, 32'h04);
        chk("R12 irq masked", irq, 0);
        chk("R12 wake masked", wake, 0);
        wr(8'h64, 32'h04); chk("R12 irq enabled", irq, 1);
        wr(8'h84, 32'h04); chk("R12 wake enabled", wake, 1);
        wr(8'h18, 32'h04); rd(8'h18, r); chk("R10 level re-sets", r, 32'h04);
        wr(8'h44, 32'h00);
        wr(8'h18, 32'hFF); rd(8'h18, r); chk("R10 clear without level", r, 0);

        // Sweep: rotate all 16 detect combinations over the pins
        wr(8'h1C, 32'hFF);
        wr(8'h80, 32'hFF); wr(8'h84, 32'h0F);
        for (int m = 0; m < 16; m++) begin
            logic [N-1:0] lo, hi, ri, fa;
            for (int i = 0; i < N; i++) begin
                logic [3:0] md;
                md = 4'((m + 3 * i) % 16);
                lo[i] = md[0]; hi[i] = md[1]; ri[i] = md[2]; fa[i] = md[3];
            end
            wr(8'h40, {24'h0, lo}); wr(8'h44, {24'h0, hi});
            wr(8'h48, {24'h0, ri}); wr(8'h4C, {24'h0, fa});
            for (int p = 0; p < 4; p++) begin
                logic [N-1:0] v0, v1, ex;
                case (p)
                    0: begin v0 = 8'h00; v1 = 8'hFF; end
                    1: begin v0 = 8'hFF; v1 = 8'h00; end
                    2: begin v0 = 8'h0F; v1 = 8'h3C; end
                    default: begin v0 = 8'hA5; v1 = 8'h5A; end
                endcase
                pin_in = v0; cycles(4);
                wr(8'h18, 32'hFF);
                rd(8'h18, r); chk("R10 after clear level only", r, {24'h0, lvl_hit(v0, lo, hi)});
                pin_in = v1; cycles(3);
                ex = lvl_hit(v0, lo, hi) | lvl_hit(v1, lo, hi)
                   | (ri & v1 & ~v0) | (fa & ~v1 & v0);
                rd(8'h18, r); chk("R11 R8 R9 combined status", r, {24'h0, ex});
                chk("R12 irq", irq, ex != 0);
                chk("R12 wake", wake, (ex & 8'h0F) != 0);
                wr(8'h18, 32'hFF);
                rd(8'h18, r); chk("R9 edge one-shot", r, {24'h0, lvl_hit(v1, lo, hi)});
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule